// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 32768 x 8 asynchronous static RAM. The host raises a request with a read/write flag, a 15-bit word address and a write byte. It holds the request until a one-cycle acknowledge comes back. Read data is returned on a registered output that keeps its value until the next read completes.

On the memory side the controller drives an active-low chip select, an active-high chip enable, an active-low write enable and an active-low output enable. It also drives the address and shares a bidirectional byte bus with the RAM. Writes are timed by the write-enable pulse. Every memory timing figure is a parameter counted in clock cycles, each at least 1: address setup before the pulse, pulse width, hold after the pulse, write recovery, read access and bus turn-around. A down-counter enforces each phase, and the sequencer moves on only when the counter has run out.

All memory-side controls come straight from registers, so they change only at clock edges. The controller drives the data bus only while a write is in progress. After a read it waits out the turn-around time with output enable released before it acknowledges. Its own drivers and the RAM's drivers are therefore never on the bus together.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, and in every idle cycle, the memory controls are quiet: chip select 1, chip enable 0, write enable 1, output enable 1, the bus is released, and acknowledge is 0.
- R2: In a write, write enable is 0 for exactly PULSE_CYC consecutive cycles. During all of them chip select is 0, chip enable is 1 and output enable is 1.
- R3: In a write, the address and write byte are on the memory pins with chip select 0 for SETUP_CYC cycles before write enable falls. They stay unchanged through the pulse, and they are still driven for HOLD_CYC cycles after write enable rises.
- R4: After the hold phase, chip select returns to 1, chip enable returns to 0 and the bus is released for RECOV_CYC cycles. The acknowledge follows these cycles.
- R5: In a read, chip select 0, chip enable 1, output enable 0 and write enable 1 last ACCESS_CYC cycles while the controller does not drive the bus. The bus is sampled at the edge that ends the last of these cycles, and the byte appears on the read-data output in the next cycle.
- R6: After a read, chip select and output enable are 1 for TURN_CYC cycles before the acknowledge. The controller never drives the bus while output enable is 0.
- R7: Acknowledge is high for exactly one cycle. It comes SETUP_CYC+PULSE_CYC+HOLD_CYC+RECOV_CYC edges after the accepting edge for a write, and ACCESS_CYC+TURN_CYC edges after it for a read.
- R8: A request is accepted only at an edge where the controller is idle and acknowledge is 0. Changes to the request fields while a transfer is busy have no effect on the memory pins or on the data written.
- R9: The read-data output keeps its value through writes and idle cycles. It changes only when a read samples the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | RAM address |
| mem_data | inout | DATA_W | RAM data bus |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_ce | output | 1 | RAM chip enable, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
The memory controls change at the edge that accepts a request. A write then steps through setup, pulse, hold and recovery, and acknowledges after SETUP+PULSE+HOLD+RECOV edges. A read acknowledges after ACCESS+TURN edges. Its byte reaches the read-data output in the first turn-around cycle.

The bench's reference model builds the whole expected per-cycle trace at the moment it accepts a request. It pops one row per clock and compares every pin on the falling edge, so each result is checked in exactly the cycle it is due. The RAM model in the bench puts a poison byte on the bus until the access count is met, so an early sample is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    // Sequencer phases of one transfer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_W_SETUP,
        PH_W_PULSE,
        PH_W_HOLD,
        PH_W_RECOV,
        PH_R_ACCESS,
        PH_R_TURN
    } phase_e;

    // Levels presented on the memory control pins plus the bus-drive flag.
    typedef struct packed {
        logic cs_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_QUIET = '{cs_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic int pick_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels belonging to each phase.
    function automatic pins_t phase_pins(input phase_e ph);
        pins_t p;
        p = PINS_QUIET;
        case (ph)
            PH_W_SETUP, PH_W_HOLD: begin
                p.cs_n  = 1'b0;
                p.ce    = 1'b1;
                p.drive = 1'b1;
            end
            PH_W_PULSE: begin
                p.cs_n  = 1'b0;
                p.ce    = 1'b1;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            PH_R_ACCESS: begin
                p.cs_n  = 1'b0;
                p.ce    = 1'b1;
                p.oe_n  = 1'b0;
            end
            default: p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 1,
    parameter int ACCESS_CYC = 1,
    parameter int TURN_CYC   = 1,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pins_t            pins,
    output logic             ack
);
    // Counter reload values: a phase of N cycles loads N-1.
    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC - 1);

    phase_e phase_q;
    phase_e phase_d;
    logic   done_d;

    always_comb begin
        phase_d  = phase_q;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done_d   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid && !ack) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        phase_d = PH_W_SETUP;
                        tmr_val = LD_SETUP;
                    end else begin
                        phase_d = PH_R_ACCESS;
                        tmr_val = LD_ACCESS;
                    end
                end
            end
            PH_W_SETUP: begin
                if (tmr_expired) begin
                    phase_d  = PH_W_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            PH_W_PULSE: begin
                if (tmr_expired) begin
                    phase_d  = PH_W_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            PH_W_HOLD: begin
                if (tmr_expired) begin
                    phase_d  = PH_W_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RECOV;
                end
            end
            PH_W_RECOV: begin
                if (tmr_expired) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_R_ACCESS: begin
                if (tmr_expired) begin
                    phase_d  = PH_R_TURN;
                    capture  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TURN;
                end
            end
            PH_R_TURN: begin
                if (tmr_expired) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Pins are registered from the next phase so they switch only at edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pins    <= PINS_QUIET;
            ack     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            pins    <= phase_pins(phase_d);
            ack     <= done_d;
        end
    end
endmodule

// File: rtl/sram_ctl_regs.sv
module sram_ctl_regs #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 1,
    parameter int ACCESS_CYC = 3,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic              mem_cs_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int T_MAX = pick_max(pick_max(pick_max(SETUP_CYC, PULSE_CYC),
                                             pick_max(HOLD_CYC, RECOV_CYC)),
                                    pick_max(ACCESS_CYC, TURN_CYC));
    localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    pins_t            pins;
    logic             bus_drive;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .RECOV_CYC  (RECOV_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .TURN_CYC   (TURN_CYC),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .accept      (accept),
        .capture     (capture),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pins        (pins),
        .ack         (ack)
    );

    sram_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_data),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata)
    );

    assign bus_drive = pins.drive;
    assign mem_cs_n  = pins.cs_n;
    assign mem_ce    = pins.ce;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_data  = bus_drive ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W    = 15,
    parameter int PULSE_CYC = 1,
    parameter int RECOV_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cs_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              bus_drive,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [15:0] we_lo_run;
    logic [15:0] we_hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_run <= '0;
            we_hi_run <= 16'hFFFF;
        end else begin
            we_lo_run <= mem_we_n ? '0 : we_lo_run + 16'd1;
            if (!mem_we_n) we_hi_run <= '0;
            else if (we_hi_run != 16'hFFFF) we_hi_run <= we_hi_run + 16'd1;
        end
    end

    AST_WRITE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_ce && mem_oe_n)); // R2
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_run == 16'(PULSE_CYC))); // R2
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
    AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(bus_drive && !mem_cs_n)); // R3
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (bus_drive && !mem_cs_n)); // R3
    AST_RECOV_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> (we_hi_run >= 16'(RECOV_CYC))); // R4
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> mem_oe_n); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R7
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_cs_n  (mem_cs_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .bus_drive (bus_drive),
    .ack       (ack),
    .mem_addr  (mem_addr)
);

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;
    localparam int S = 2, P = 3, H = 1, RC = 2, A = 4, Z = 2;

    typedef struct packed {
        logic        cs_n;
        logic        ce;
        logic        we_n;
        logic        oe_n;
        logic        drv;
        logic        ack;
        logic [14:0] addr;
        logic [7:0]  data;
        logic [7:0]  rdata;
        logic [3:0]  tag;
    } row_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [14:0] mem_addr;
    wire  [7:0]  mem_data;
    logic        mem_cs_n, mem_ce, mem_we_n, mem_oe_n;

    int n_checks = 0;
    int n_err = 0;
    bit armed = 1'b0;
    bit scr_active = 1'b0;

    always #2 clk = ~clk;

    sram_ctl #(
        .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .RECOV_CYC(RC), .ACCESS_CYC(A), .TURN_CYC(Z)
    ) u_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_cs_n(mem_cs_n),
        .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // ---------------- RAM model ----------------
    logic [7:0] ram [int];
    logic [7:0] ram_q;
    logic       ram_on;
    int         acc_cnt = 0;

    function automatic logic [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    assign ram_on = !mem_cs_n && mem_ce && !mem_oe_n && mem_we_n;
    always @(posedge clk) acc_cnt <= ram_on ? acc_cnt + 1 : 0;
    always_comb ram_q = (acc_cnt >= A - 1) ? ram_rd(int'(mem_addr)) : 8'hEE;
    assign mem_data = ram_on ? ram_q : 8'bz;
    always @(posedge mem_we_n) if (!rst && !mem_cs_n && mem_ce) ram[int'(mem_addr)] = mem_data;

    // ---------------- reference model ----------------
    logic [7:0]  ref_mem [int];
    row_t        q[$];
    row_t        cur;
    logic [14:0] last_addr = '0;
    logic [7:0]  last_rd = '0;

    function automatic row_t quiet(input logic [3:0] tag);
        row_t r;
        r = '0;
        r.cs_n = 1'b1; r.we_n = 1'b1; r.oe_n = 1'b1;
        r.addr = last_addr; r.rdata = last_rd; r.tag = tag;
        return r;
    endfunction

    task automatic build();
        row_t r;
        last_addr = req_addr;
        if (req_write) begin
            ref_mem[int'(req_addr)] = req_wdata;
            r = quiet(4'd3);
            r.cs_n = 1'b0; r.ce = 1'b1; r.drv = 1'b1; r.data = req_wdata;
            for (int i = 0; i < S; i++) q.push_back(r);
            r.we_n = 1'b0; r.tag = 4'd2;
            for (int i = 0; i < P; i++) q.push_back(r);
            r.we_n = 1'b1; r.tag = 4'd3;
            for (int i = 0; i < H; i++) q.push_back(r);
            r = quiet(4'd4);
            for (int i = 0; i < RC; i++) q.push_back(r);
        end else begin
            r = quiet(4'd5);
            r.cs_n = 1'b0; r.ce = 1'b1; r.oe_n = 1'b0;
            for (int i = 0; i < A; i++) q.push_back(r);
            last_rd = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
            r = quiet(4'd6);
            for (int i = 0; i < Z; i++) q.push_back(r);
        end
        r = quiet(4'd7);
        r.ack = 1'b1;
        q.push_back(r);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = quiet(4'd1);
        end else if (q.size() != 0) begin
            cur = q.pop_front();
        end else if (req_valid && !cur.ack) begin // R8: accept only idle with ack low
            build();
            cur = q.pop_front();
        end else begin
            cur = quiet(4'd1);
        end
        armed = 1'b1;
    end

    // ---------------- checking ----------------
    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk({mem_cs_n, mem_ce, mem_we_n, mem_oe_n} == {cur.cs_n, cur.ce, cur.we_n, cur.oe_n},
                tname(cur.tag), "pins", int'({mem_cs_n, mem_ce, mem_we_n, mem_oe_n}),
                int'({cur.cs_n, cur.ce, cur.we_n, cur.oe_n}));
            chk(ack == cur.ack, "R7", "ack", int'(ack), int'(cur.ack));
            if (!rst)
                chk(mem_addr == cur.addr, scr_active ? "R8" : "R3", "addr",
                    int'(mem_addr), int'(cur.addr));
            if (cur.drv)
                chk(mem_data == cur.data, scr_active ? "R8" : "R3", "wdata",
                    int'(mem_data), int'(cur.data));
            chk(rdata == cur.rdata, (cur.tag == 4'd6) ? "R5" : "R9", "rdata",
                int'(rdata), int'(cur.rdata));
        end
    end

    // Called at a falling edge; returns at the falling edge where ack is seen.
    task automatic xfer(input bit w, input logic [14:0] a, input logic [7:0] d, input bit scramble);
        int n;
        n = 0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk);
            n++;
            if (scramble && n == 3) begin // R8: fields change while busy
                scr_active = 1'b1;
                req_addr = ~a; req_wdata = ~d; req_write = !w;
            end
        end while (!ack);
        scr_active = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        xfer(1'b1, 15'h1234, 8'hA5, 1'b0);     // R2 R3 R4 R7
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        xfer(1'b0, 15'h1234, 8'h00, 1'b0);     // R5 R6
        xfer(1'b1, 15'h7FFF, 8'h3C, 1'b0);     // back to back, R8 ack guard
        xfer(1'b1, 15'h0000, 8'h5A, 1'b0);
        xfer(1'b0, 15'h7FFF, 8'h00, 1'b0);
        xfer(1'b0, 15'h0000, 8'h00, 1'b0);
        xfer(1'b0, 15'h0042, 8'h00, 1'b0);     // unwritten word reads 0
        xfer(1'b1, 15'h0042, 8'hC3, 1'b1);     // R8 scrambled write
        req_valid = 1'b0;
        repeat (3) @(negedge clk);             // R9 rdata holds through idle
        xfer(1'b0, 15'h0042, 8'h00, 1'b1);     // R8 scrambled read
        xfer(1'b0, ~15'h0042, 8'h00, 1'b0);    // scramble left nothing behind
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 15'(i * 4097), 8'(8'h11 << (i % 4)) ^ 8'(i), 1'b0); // R9 writes keep rdata
            xfer(1'b0, 15'(i * 4097), 8'h00, 1'b0);
        end
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule